// File: doc/BRIEF.md
# Shadow-Buffered Receive Mailbox

This block is a single receive-only message mailbox for a CAN controller. Every message the protocol engine delivers lands first in a hidden one-entry shadow buffer. The processor only ever sees the visible mailbox: identifier, length and up to eight data bytes. The shadow contents move into the visible mailbox on their own as soon as the processor has released the mailbox. Releasing means that both the data-updated flag and the external-request flag read zero.

The processor sees the flags through one status vector and clears them by writing zeros through a flag-write port. A 1 in a written bit leaves that flag as it was. The overwrite flag describes the hidden shadow buffer. It goes high when a message replaces shadow contents that had not yet been moved. It drops when those contents are transferred. A transmit-inhibit field sits in the write vector, but this mailbox never transmits, so the field is accepted and discarded.

Top module: `rx_shadow_mailbox`

## Requirements
- R1: After reset all five flag bits read 0, the visible mailbox reads identifier 0, length 0 and data 0, and the shadow is empty.
- R2: A message accepted on `msg_valid` while the mailbox is free and the shadow is empty appears on the mailbox outputs on the second rising edge after it is presented. The same edge sets data-updated (flag bit 0).
- R3: While data-updated or external-request is 1, the visible mailbox keeps its contents, and a waiting message stays in the shadow.
- R4: A transfer happens on the first edge at which the shadow holds a message and both data-updated and external-request are 0. A transfer copies the shadow into the mailbox and sets data-updated.
- R5: A message arriving while the shadow holds an untransferred message replaces the shadow contents and sets the overwrite flag (flag bit 4).
- R6: A transfer clears the overwrite flag and empties the shadow. No further transfer follows until a new message arrives. A message arriving on the transfer edge refills the shadow without setting overwrite.
- R7: Data-updated falls only on a processor write with bit 0 equal to 0, on reset, or on soft reset. Writing 1 never sets it. If a transfer and a clearing write land on the same edge, the transfer wins.
- R8: `remote_req` sets external-request (flag bit 1). A processor write with bit 1 equal to 0 clears it, and `remote_req` wins on the same edge.
- R9: A transfer with `irq_en` high sets the interrupt-request flag (flag bit 3). A transfer with `irq_en` low leaves it unchanged. A write with bit 3 equal to 0 clears it.
- R10: The transmit-inhibit field (write bit 2) has no effect: flag bit 2 always reads 0, and transfers proceed regardless of the value written there.
- R11: The stored length is clamped to 8. Data bytes at index equal to or above the stored length are stored as zero. Byte i occupies data bits 8i+7..8i.
- R12: `soft_rst` clears all flags and empties the shadow, dropping any waiting message or a message arriving on the same edge. The visible mailbox contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Controller soft reset, synchronous |
| irq_en | input | 1 | Receive interrupt enable |
| msg_valid | input | 1 | Message strobe from the protocol engine |
| msg_id | input | ID_W | Message identifier |
| msg_len | input | LEN_W | Data length in bytes |
| msg_data | input | DATA_W | Data bytes, byte 0 in the low bits |
| remote_req | input | 1 | Remote request for this mailbox; sets external-request |
| flag_wr | input | 1 | Processor flag write strobe |
| flag_wdata | input | 5 | Write value: a 0 in bit 0, 1 or 3 clears that flag; bits 2 and 4 are ignored |
| flags_rd | output | 5 | {overwrite, irq, 0, external-request, data-updated} |
| mb_id | output | ID_W | Visible mailbox identifier |
| mb_len | output | LEN_W | Visible mailbox length |
| mb_data | output | DATA_W | Visible mailbox data |

## Verification
A wrong shadow-full state shows up at the ports within one edge of the processor releasing the mailbox. A spurious transfer rewrites `mb_id` and raises data-updated, and a lost message leaves data-updated low one edge too long. A wrong overwrite flag or interrupt flag is directly visible in `flags_rd` on the next edge. A wrong masking or length clamp shows in `mb_data` and `mb_len` on the edge the message is transferred. Comparing these ports every cycle against the reference model therefore exposes any internal slip within one or two cycles.

// File: rtl/rxmbx_pkg.sv
package rxmbx_pkg;
  // Bit positions of the flag vector seen by the processor.
  localparam int FLG_DTUP = 0;
  localparam int FLG_XREQ = 1;
  localparam int FLG_INH  = 2;
  localparam int FLG_IRQ  = 3;
  localparam int FLG_OVW  = 4;
  localparam int FLG_W    = 5;
endpackage

// File: rtl/rxmbx_shadow.sv
module rxmbx_shadow #(
  parameter int ID_W   = 29,
  parameter int NBYTES = 8,
  parameter int LEN_W  = 4,
  localparam int DATA_W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer_go,
  output logic              full,
  output logic              ovw,
  output logic [ID_W-1:0]   sh_id,
  output logic [LEN_W-1:0]  sh_len,
  output logic [DATA_W-1:0] sh_data
);
  // Length above the mailbox capacity is clamped to the capacity.
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l > LEN_W'(NBYTES)) return LEN_W'(NBYTES);
    return l;
  endfunction

  // Zero every byte whose index is at or above the stored length.
  function automatic logic [DATA_W-1:0] mask_bytes(input logic [DATA_W-1:0] d,
                                                   input logic [LEN_W-1:0]  l);
    logic [DATA_W-1:0] r;
    r = d;
    for (int b = 0; b < NBYTES; b++) begin
      if (LEN_W'(b) >= l) r[8*b +: 8] = 8'h00;
    end
    return r;
  endfunction

  logic [LEN_W-1:0] len_c;
  logic             refill_while_full;

  assign len_c             = clamp_len(wr_len);
  assign refill_while_full = wr_en && full && !xfer_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      ovw     <= 1'b0;
      sh_id   <= '0;
      sh_len  <= '0;
      sh_data <= '0;
    end else if (soft_rst) begin
      full <= 1'b0;
      ovw  <= 1'b0;
    end else begin
      if (wr_en) begin
        full    <= 1'b1;
        sh_id   <= wr_id;
        sh_len  <= len_c;
        sh_data <= mask_bytes(wr_data, len_c);
      end else if (xfer_go) begin
        full <= 1'b0;
      end
      if (xfer_go)                ovw <= 1'b0;
      else if (refill_while_full) ovw <= 1'b1;
    end
  end

  // R5
  shadow_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !xfer_go && !soft_rst) |=> ovw);

  // R6
  transfer_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !wr_en) |=> (!full && !ovw));

  // R6
  transfer_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && wr_en && !soft_rst) |=> (full && !ovw));
endmodule

// File: rtl/rxmbx_flags.sv
module rxmbx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic xfer_go,
  input  logic irq_en,
  input  logic remote_req,
  input  logic clr_dtup,
  input  logic clr_xreq,
  input  logic clr_irq,
  output logic dtup,
  output logic xreq,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtup <= 1'b0;
      xreq <= 1'b0;
      irq  <= 1'b0;
    end else if (soft_rst) begin
      dtup <= 1'b0;
      xreq <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (xfer_go)       dtup <= 1'b1;
      else if (clr_dtup) dtup <= 1'b0;
      if (remote_req)    xreq <= 1'b1;
      else if (clr_xreq) xreq <= 1'b0;
      if (xfer_go && irq_en) irq <= 1'b1;
      else if (clr_irq)      irq <= 1'b0;
    end
  end

  // R7
  dtup_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtup) |-> $past(clr_dtup || soft_rst));

  // R8
  xreq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_req && !soft_rst) |=> xreq);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && irq_en) |=> irq);
endmodule

// File: rtl/rxmbx_store.sv
module rxmbx_store #(
  parameter int ID_W   = 29,
  parameter int NBYTES = 8,
  parameter int LEN_W  = 4,
  localparam int DATA_W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ID_W-1:0]   in_id,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DATA_W-1:0] in_data,
  output logic [ID_W-1:0]   mb_id,
  output logic [LEN_W-1:0]  mb_len,
  output logic [DATA_W-1:0] mb_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_id   <= '0;
      mb_len  <= '0;
      mb_data <= '0;
    end else if (load) begin
      mb_id   <= in_id;
      mb_len  <= in_len;
      mb_data <= in_data;
    end
  end
endmodule

// File: rtl/rx_shadow_mailbox.sv
module rx_shadow_mailbox #(
  parameter int ID_W   = 29,
  parameter int NBYTES = 8,
  localparam int LEN_W  = $clog2(NBYTES + 1),
  localparam int DATA_W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              irq_en,
  input  logic              msg_valid,
  input  logic [ID_W-1:0]   msg_id,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic [DATA_W-1:0] msg_data,
  input  logic              remote_req,
  input  logic              flag_wr,
  input  logic [4:0]        flag_wdata,
  output logic [4:0]        flags_rd,
  output logic [ID_W-1:0]   mb_id,
  output logic [LEN_W-1:0]  mb_len,
  output logic [DATA_W-1:0] mb_data
);
  import rxmbx_pkg::*;

  logic              sh_full, sh_ovw;
  logic [ID_W-1:0]   sh_id;
  logic [LEN_W-1:0]  sh_len;
  logic [DATA_W-1:0] sh_data;
  logic              dtup, xreq, irq;
  logic              xfer_go;
  logic              clr_dtup, clr_xreq, clr_irq;
  logic              unused_wr_bits;

  // A written 0 clears; the inhibit and overwrite positions are discarded.
  assign clr_dtup       = flag_wr && !flag_wdata[FLG_DTUP];
  assign clr_xreq       = flag_wr && !flag_wdata[FLG_XREQ];
  assign clr_irq        = flag_wr && !flag_wdata[FLG_IRQ];
  assign unused_wr_bits = flag_wdata[FLG_INH] ^ flag_wdata[FLG_OVW];

  // Mailbox released by the processor and a message waiting.
  assign xfer_go = sh_full && !dtup && !xreq && !soft_rst;

  rxmbx_shadow #(.ID_W(ID_W), .NBYTES(NBYTES), .LEN_W(LEN_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(msg_valid), .wr_id(msg_id), .wr_len(msg_len), .wr_data(msg_data),
    .xfer_go(xfer_go), .full(sh_full), .ovw(sh_ovw),
    .sh_id(sh_id), .sh_len(sh_len), .sh_data(sh_data)
  );

  rxmbx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .xfer_go(xfer_go),
    .irq_en(irq_en), .remote_req(remote_req),
    .clr_dtup(clr_dtup), .clr_xreq(clr_xreq), .clr_irq(clr_irq),
    .dtup(dtup), .xreq(xreq), .irq(irq)
  );

  rxmbx_store #(.ID_W(ID_W), .NBYTES(NBYTES), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(xfer_go),
    .in_id(sh_id), .in_len(sh_len), .in_data(sh_data),
    .mb_id(mb_id), .mb_len(mb_len), .mb_data(mb_data)
  );

  always_comb begin
    flags_rd           = '0;
    flags_rd[FLG_DTUP] = dtup;
    flags_rd[FLG_XREQ] = xreq;
    flags_rd[FLG_IRQ]  = irq;
    flags_rd[FLG_OVW]  = sh_ovw;
  end

  // R3
  held_mailbox_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtup || xreq) |=> ($stable(mb_id) && $stable(mb_len) && $stable(mb_data)));

  // R4
  transfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> (dtup && mb_id == $past(sh_id) && mb_data == $past(sh_data)));
endmodule

// File: tb/tb_rx_shadow_mailbox.sv
module tb_rx_shadow_mailbox;
  localparam int ID_W = 29;
  localparam int NB   = 8;
  localparam int LW   = 4;
  localparam int DW   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, irq_en = 1'b1, msg_valid = 1'b0, remote_req = 1'b0, flag_wr = 1'b0;
  logic [ID_W-1:0] msg_id = '0;
  logic [LW-1:0]   msg_len = '0;
  logic [DW-1:0]   msg_data = '0;
  logic [4:0]      flag_wdata = '1;
  logic [4:0]      flags_rd;
  logic [ID_W-1:0] mb_id;
  logic [LW-1:0]   mb_len;
  logic [DW-1:0]   mb_data;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  rx_shadow_mailbox #(.ID_W(ID_W), .NBYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_en(irq_en),
    .msg_valid(msg_valid), .msg_id(msg_id), .msg_len(msg_len), .msg_data(msg_data),
    .remote_req(remote_req), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .flags_rd(flags_rd), .mb_id(mb_id), .mb_len(mb_len), .mb_data(mb_data)
  );

  // Behavioural reference model
  bit m_full, m_ovw, m_dtup, m_xreq, m_irq;
  logic [ID_W-1:0] m_sid, m_mid;
  int              m_slen, m_mlen;
  logic [DW-1:0]   m_sdat, m_mdat;

  function automatic int eff_len(input int l);
    return (l > NB) ? NB : l;
  endfunction

  function automatic logic [DW-1:0] keep_low(input logic [DW-1:0] d, input int l);
    logic [DW-1:0] m;
    if (l >= NB) m = '1;
    else m = (64'd1 << (8 * l)) - 64'd1;
    return d & m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = 0; m_ovw = 0; m_dtup = 0; m_xreq = 0; m_irq = 0;
      m_sid = '0; m_mid = '0; m_slen = 0; m_mlen = 0; m_sdat = '0; m_mdat = '0;
    end else if (soft_rst) begin
      m_full = 0; m_ovw = 0; m_dtup = 0; m_xreq = 0; m_irq = 0;
    end else begin
      bit go;
      go = m_full && !m_dtup && !m_xreq;
      if (go) begin m_mid = m_sid; m_mlen = m_slen; m_mdat = m_sdat; end
      if (flag_wr && flag_wdata[0] == 1'b0) m_dtup = 0;
      if (go) m_dtup = 1;
      if (flag_wr && flag_wdata[1] == 1'b0) m_xreq = 0;
      if (remote_req) m_xreq = 1;
      if (flag_wr && flag_wdata[3] == 1'b0) m_irq = 0;
      if (go && irq_en) m_irq = 1;
      if (go) m_ovw = 0;
      else if (msg_valid && m_full) m_ovw = 1;
      if (go) m_full = 0;
      if (msg_valid) begin
        m_full = 1;
        m_sid  = msg_id;
        m_slen = eff_len(int'(msg_len));
        m_sdat = keep_low(msg_data, m_slen);
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] ef;
      ef = {m_ovw, m_irq, 1'b0, m_xreq, m_dtup};
      tests++;
      if (flags_rd !== ef) begin
        fails++;
        $display("FAIL R7 model flags act=%b exp=%b", flags_rd, ef);
      end
      tests++;
      if (mb_id !== m_mid || int'(mb_len) != m_mlen || mb_data !== m_mdat) begin
        fails++;
        $display("FAIL R4 model mailbox act=%h/%0d/%h exp=%h/%0d/%h",
                 mb_id, mb_len, mb_data, m_mid, m_mlen, m_mdat);
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [ID_W-1:0] id, input int len, input logic [DW-1:0] d);
    @(negedge clk);
    msg_valid = 1'b1; msg_id = id; msg_len = LW'(len); msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic wr_flags(input logic [4:0] v);
    @(negedge clk);
    flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk);
    flag_wr = 1'b0; flag_wdata = '1;
  endtask

  task automatic pulse_remote();
    @(negedge clk); remote_req = 1'b1;
    @(negedge clk); remote_req = 1'b0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  localparam logic [ID_W-1:0] IDA = 29'h0000123, IDB = 29'h0000456, IDC = 29'h1ABCDEF;
  localparam logic [DW-1:0] DA = 64'h0807060504030201, DB = 64'h1111111111111111,
                            DC = 64'hCAFEF00DDEADBEEF;

  initial begin : watchdog
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flags", 64'(flags_rd), 64'h0);
    check("R1 reset id", 64'(mb_id), 64'h0);
    check("R1 reset data", mb_data, 64'h0);
    rst_n = 1'b1;

    send(IDA, 8, DA);
    @(negedge clk);
    check("R2 id", 64'(mb_id), 64'(IDA));
    check("R2 data", mb_data, DA);
    check("R9 flags after transfer", 64'(flags_rd), 64'b01001);

    send(IDB, 8, DB);
    @(negedge clk);
    check("R3 mailbox held", 64'(mb_id), 64'(IDA));
    send(IDC, 8, DC);
    check("R5 overwrite set", 64'(flags_rd), 64'b11001);

    wr_flags(5'b11111);
    check("R10 inhibit and ones ignored", 64'(flags_rd), 64'b11001);

    pulse_remote();
    check("R8 xreq set", 64'(flags_rd), 64'b11011);
    wr_flags(5'b11110);
    check("R4 dtup cleared only", 64'(flags_rd), 64'b11010);
    @(negedge clk);
    check("R4 no transfer with xreq", 64'(mb_id), 64'(IDA));

    wr_flags(5'b11101);
    check("R8 xreq cleared", 64'(flags_rd), 64'b11000);
    @(negedge clk);
    check("R5 replaced message moved", 64'(mb_id), 64'(IDC));
    check("R5 replaced data moved", mb_data, DC);
    check("R6 overwrite cleared", 64'(flags_rd), 64'b01001);

    wr_flags(5'b11110);
    repeat (3) @(negedge clk);
    check("R6 shadow empty no transfer", 64'(flags_rd), 64'b01000);
    check("R6 mailbox kept", 64'(mb_id), 64'(IDC));

    send(29'h7, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    check("R11 short len", 64'(mb_len), 64'd3);
    check("R11 masked data", mb_data, 64'h0000_0000_00FF_FFFF);
    wr_flags(5'b11110);
    send(29'h8, 13, DC);
    @(negedge clk);
    check("R11 clamped len", 64'(mb_len), 64'd8);
    check("R11 full data", mb_data, DC);

    irq_en = 1'b0;
    wr_flags(5'b10110);
    check("R9 irq cleared", 64'(flags_rd), 64'h0);
    send(29'h9, 2, DB);
    @(negedge clk);
    check("R9 no irq when disabled", 64'(flags_rd), 64'b00001);

    send(29'hA, 4, DA);
    pulse_soft();
    check("R12 flags cleared", 64'(flags_rd), 64'h0);
    repeat (3) @(negedge clk);
    check("R12 waiting message dropped", 64'(mb_id), 64'h9);
    check("R12 no transfer", 64'(flags_rd), 64'h0);

    irq_en = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      msg_valid  = ($urandom % 100) < 35;
      msg_id     = ID_W'($urandom);
      msg_len    = LW'($urandom);
      msg_data   = {$urandom, $urandom};
      remote_req = ($urandom % 100) < 6;
      flag_wr    = ($urandom % 100) < 30;
      flag_wdata = 5'($urandom);
      soft_rst   = ($urandom % 100) < 2;
      if (($urandom % 50) == 0) irq_en = ~irq_en;
    end
    @(negedge clk);
    msg_valid = 0; remote_req = 0; flag_wr = 0; soft_rst = 0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule